// File: doc/BRIEF.md
# SPI-to-Register Burst Bridge

This block is an SPI mode-0 slave that turns serial burst transactions into single-cycle accesses on a parallel control/status register port. The SPI pins are oversampled in the system clock domain, so SCLK must run at no more than one eighth of the system clock. A transaction opens with a 24-bit header that gives the direction, the addressing style, the number of words and an 8-bit start address. A stream of 16-bit data words follows.

In a write transaction each complete data word becomes one register write. In a read transaction the bridge fetches each word from the register port before that word is due on MISO. The first read word follows the header with no gap. Incremental bursts step the address by one for each word and suit register arrays. Fixed bursts keep one address for every word and suit FIFO ports. Raising chip select ends a transaction at any point.

Top module: `spi_csr_bridge`

## Requirements
- R1: SPI mode 0. MOSI is sampled on rising SCLK edges and MISO changes after falling edges. Bits move most significant first. The 24-bit header carries these fields: bit 23 is direction (1 = write, 0 = read), bit 22 is addressing (1 = incremental, 0 = fixed), bits 21:8 hold the word count minus one, and bits 7:0 hold the start address.
- R2: In a write transaction, every complete 16-bit data word (high byte first) produces exactly one register access with `csr_valid`=1, `csr_we`=1 and `csr_wdata` equal to that word.
- R3: In an incremental burst, word k uses address start+k, taken modulo 256 (0xFF is followed by 0x00).
- R4: In a fixed burst, every word uses the start address.
- R5: A transaction performs exactly count-field+1 word accesses. A field of 0 means one word, and the full 14-bit field is honoured (no early end at 0x3FFF).
- R6: In a read transaction, the first register read is issued once the header is complete, and each further read is issued once the previous word has fully shifted. The read data appears on MISO starting with the first data bit after the header, MSB first, with no dummy bits.
- R7: Chip select going high ends the transaction. A partly received write word is dropped without any register access, and the next transaction starts cleanly.
- R8: Once the counted words are done, further SCLK activity in the same transaction causes no register access, and MISO stays 0.
- R9: MISO is 0 during the header, throughout write transactions and while chip select is high.
- R10: After reset, `csr_valid` and `spi_miso` are 0.
- R11: `csr_valid` is a single-cycle pulse for every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data into the bridge |
| spi_miso | output | 1 | SPI data out of the bridge, 0 when idle |
| csr_valid | output | 1 | Register access strobe, one cycle |
| csr_we | output | 1 | 1 = write, 0 = read |
| csr_addr | output | ADDR_W | Register address |
| csr_wdata | output | WORD_W | Write data |
| csr_rdata | input | WORD_W | Read data, valid with csr_rvalid |
| csr_rvalid | input | 1 | Read data valid, one cycle after a read strobe |

## Verification
A wrong bit counter or header latch shows up at the register port within one word. The access then lands at a shifted address, carries rotated data or arrives in the wrong number. A wrong remaining-word count appears as a missing or extra strobe at the end of the burst, or as an early stop in a long burst. A transmit path that loads late or shifts on the wrong edge corrupts the first MISO bits of a read word in that same word. Stale state left after an abort shows up in the very next transaction's first access.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  // Transaction phase of the sequencer.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } phase_t;

endpackage

// File: rtl/bridge_sync.sv
// Reset release synchronizer, pin synchronizers and SCLK edge detection.
module bridge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  input  logic sclk,
  input  logic mosi,
  input  logic cs_n,
  output logic rst_n,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s,
  output logic cs_n_s
);

  localparam int NPIN = 3;
  // Per-pin reset value: chip select idles high, the others low.
  localparam logic [NPIN-1:0] PIN_RST = 3'b100;

  logic [1:0] rst_pipe_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) rst_pipe_q <= 2'b00;
    else           rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_n = rst_pipe_q[1];

  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_s;

  assign pin_raw = {cs_n, mosi, sclk};

  for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{PIN_RST[gi]}};
      else        pipe_q <= {pipe_q[STAGES-2:0], pin_raw[gi]};
    end
    assign pin_s[gi] = pipe_q[STAGES-1];
  end

  logic sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= pin_s[0];
  end

  assign sclk_rise = pin_s[0] & ~sclk_prev_q;
  assign sclk_fall = ~pin_s[0] & sclk_prev_q;
  assign mosi_s    = pin_s[1];
  assign cs_n_s    = pin_s[2];

endmodule

// File: rtl/bridge_rx.sv
// Receive shifter: counts header bits, then word bits, and flags completion.
module bridge_rx #(
  parameter int HDR_W  = 24,
  parameter int WORD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_s,
  input  logic             sclk_rise,
  input  logic             mosi_s,
  output logic [HDR_W-1:0] shreg,
  output logic             hdr_done,
  output logic             word_done
);

  localparam int CNT_W = $clog2(HDR_W + 1);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

  logic [HDR_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             in_hdr_q, in_hdr_d;
  logic             hdr_done_q, hdr_done_d;
  logic             word_done_q, word_done_d;

  always_comb begin
    shreg_d     = shreg_q;
    cnt_d       = cnt_q;
    in_hdr_d    = in_hdr_q;
    hdr_done_d  = 1'b0;
    word_done_d = 1'b0;
    if (cs_n_s) begin
      shreg_d  = '0;
      cnt_d    = '0;
      in_hdr_d = 1'b1;
    end else if (sclk_rise) begin
      shreg_d = {shreg_q[HDR_W-2:0], mosi_s};
      if (in_hdr_q && cnt_q == HDR_LAST) begin
        cnt_d      = '0;
        in_hdr_d   = 1'b0;
        hdr_done_d = 1'b1;
      end else if (!in_hdr_q && cnt_q == WORD_LAST) begin
        cnt_d       = '0;
        word_done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q     <= '0;
      cnt_q       <= '0;
      in_hdr_q    <= 1'b1;
      hdr_done_q  <= 1'b0;
      word_done_q <= 1'b0;
    end else begin
      shreg_q     <= shreg_d;
      cnt_q       <= cnt_d;
      in_hdr_q    <= in_hdr_d;
      hdr_done_q  <= hdr_done_d;
      word_done_q <= word_done_d;
    end
  end

  assign shreg     = shreg_q;
  assign hdr_done  = hdr_done_q;
  assign word_done = word_done_q;

endmodule

// File: rtl/bridge_seq.sv
// Burst sequencer: header decode, address/count tracking, register strobes, MISO shifter.
module bridge_seq
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 14,
  parameter int WORD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n_s,
  input  logic                 sclk_fall,
  input  logic                 hdr_done,
  input  logic                 word_done,
  input  logic [2+LEN_W+ADDR_W-1:0] shreg,
  input  logic [WORD_W-1:0]    csr_rdata,
  input  logic                 csr_rvalid,
  output logic                 csr_valid,
  output logic                 csr_we,
  output logic [ADDR_W-1:0]    csr_addr,
  output logic [WORD_W-1:0]    csr_wdata,
  output logic                 miso,
  output logic                 burst_incr,
  output logic [LEN_W:0]       burst_words
);

  localparam int HDR_W   = 2 + LEN_W + ADDR_W;
  localparam int WR_POS  = HDR_W - 1;
  localparam int INC_POS = HDR_W - 2;
  localparam int LEN_POS = ADDR_W;
  localparam logic [LEN_W:0] ONE_WORD = (LEN_W+1)'(1);

  phase_t              phase_q, phase_d;
  logic                wr_q, wr_d;
  logic                incr_q, incr_d;
  logic [LEN_W:0]      left_q, left_d;
  logic [LEN_W:0]      words_q, words_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [ADDR_W-1:0]   step_addr;
  logic                csr_valid_q, csr_valid_d;
  logic                csr_we_q, csr_we_d;
  logic [ADDR_W-1:0]   csr_addr_q, csr_addr_d;
  logic [WORD_W-1:0]   csr_wdata_q, csr_wdata_d;
  logic [WORD_W-1:0]   tx_q, tx_d;
  logic                miso_q, miso_d;

  assign step_addr = addr_q + ADDR_W'(incr_q);

  always_comb begin
    phase_d     = phase_q;
    wr_d        = wr_q;
    incr_d      = incr_q;
    left_d      = left_q;
    words_d     = words_q;
    addr_d      = addr_q;
    csr_valid_d = 1'b0;
    csr_we_d    = csr_we_q;
    csr_addr_d  = csr_addr_q;
    csr_wdata_d = csr_wdata_q;
    tx_d        = tx_q;
    miso_d      = miso_q;
    if (cs_n_s) begin
      phase_d = PH_IDLE;
      tx_d    = '0;
      miso_d  = 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: phase_d = PH_HDR;
        PH_HDR: begin
          if (hdr_done) begin
            wr_d    = shreg[WR_POS];
            incr_d  = shreg[INC_POS];
            words_d = {1'b0, shreg[LEN_POS +: LEN_W]} + ONE_WORD;
            left_d  = {1'b0, shreg[LEN_POS +: LEN_W]} + ONE_WORD;
            addr_d  = shreg[ADDR_W-1:0];
            phase_d = PH_DATA;
            if (!shreg[WR_POS]) begin
              csr_valid_d = 1'b1;
              csr_we_d    = 1'b0;
              csr_addr_d  = shreg[ADDR_W-1:0];
            end
          end
        end
        PH_DATA: begin
          if (word_done) begin
            addr_d = step_addr;
            left_d = left_q - ONE_WORD;
            if (wr_q) begin
              csr_valid_d = 1'b1;
              csr_we_d    = 1'b1;
              csr_addr_d  = addr_q;
              csr_wdata_d = shreg[WORD_W-1:0];
            end
            if (left_q == ONE_WORD) begin
              phase_d = PH_DONE;
            end else if (!wr_q) begin
              csr_valid_d = 1'b1;
              csr_we_d    = 1'b0;
              csr_addr_d  = step_addr;
            end
          end
        end
        default: ;
      endcase
      if (csr_rvalid && !wr_q && (phase_q == PH_DATA || phase_q == PH_DONE)) begin
        tx_d = csr_rdata;
      end
      if (sclk_fall) begin
        miso_d = tx_q[WORD_W-1];
        tx_d   = {tx_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      wr_q        <= 1'b0;
      incr_q      <= 1'b0;
      left_q      <= '0;
      words_q     <= '0;
      addr_q      <= '0;
      csr_valid_q <= 1'b0;
      csr_we_q    <= 1'b0;
      csr_addr_q  <= '0;
      csr_wdata_q <= '0;
      tx_q        <= '0;
      miso_q      <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      wr_q        <= wr_d;
      incr_q      <= incr_d;
      left_q      <= left_d;
      words_q     <= words_d;
      addr_q      <= addr_d;
      csr_valid_q <= csr_valid_d;
      csr_we_q    <= csr_we_d;
      csr_addr_q  <= csr_addr_d;
      csr_wdata_q <= csr_wdata_d;
      tx_q        <= tx_d;
      miso_q      <= miso_d;
    end
  end

  assign csr_valid   = csr_valid_q;
  assign csr_we      = csr_we_q;
  assign csr_addr    = csr_addr_q;
  assign csr_wdata   = csr_wdata_q;
  assign miso        = miso_q;
  assign burst_incr  = incr_q;
  assign burst_words = words_q;

endmodule

// File: rtl/spi_csr_bridge.sv
// Top: SPI mode-0 slave to register-port burst bridge.
module spi_csr_bridge #(
  parameter int ADDR_W      = 8,
  parameter int LEN_W       = 14,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              csr_valid,
  output logic              csr_we,
  output logic [ADDR_W-1:0] csr_addr,
  output logic [WORD_W-1:0] csr_wdata,
  input  logic [WORD_W-1:0] csr_rdata,
  input  logic              csr_rvalid
);

  localparam int HDR_W = 2 + LEN_W + ADDR_W;

  logic             rst_n_s;
  logic             sclk_rise;
  logic             sclk_fall;
  logic             mosi_s;
  logic             cs_n_s;
  logic [HDR_W-1:0] rx_shreg;
  logic             hdr_done;
  logic             word_done;
  logic             burst_incr;
  logic [LEN_W:0]   burst_words;

  bridge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .cs_n      (spi_cs_n),
    .rst_n     (rst_n_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_s    (mosi_s),
    .cs_n_s    (cs_n_s)
  );

  bridge_rx #(
    .HDR_W  (HDR_W),
    .WORD_W (WORD_W)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cs_n_s    (cs_n_s),
    .sclk_rise (sclk_rise),
    .mosi_s    (mosi_s),
    .shreg     (rx_shreg),
    .hdr_done  (hdr_done),
    .word_done (word_done)
  );

  bridge_seq #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .WORD_W (WORD_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .cs_n_s      (cs_n_s),
    .sclk_fall   (sclk_fall),
    .hdr_done    (hdr_done),
    .word_done   (word_done),
    .shreg       (rx_shreg),
    .csr_rdata   (csr_rdata),
    .csr_rvalid  (csr_rvalid),
    .csr_valid   (csr_valid),
    .csr_we      (csr_we),
    .csr_addr    (csr_addr),
    .csr_wdata   (csr_wdata),
    .miso        (spi_miso),
    .burst_incr  (burst_incr),
    .burst_words (burst_words)
  );

endmodule

// File: rtl/bridge_checker.sv
// Protocol checker, attached to the bridge top by bind.
module bridge_checker #(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n_s,
  input logic              csr_valid,
  input logic [ADDR_W-1:0] csr_addr,
  input logic              spi_miso,
  input logic              burst_incr,
  input logic [LEN_W:0]    burst_words
);

  logic              seen_q;
  logic [ADDR_W-1:0] prev_addr_q;
  logic [LEN_W:0]    issued_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      prev_addr_q <= '0;
      issued_q    <= '0;
    end else if (cs_n_s) begin
      seen_q   <= 1'b0;
      issued_q <= '0;
    end else if (csr_valid) begin
      seen_q      <= 1'b1;
      prev_addr_q <= csr_addr;
      issued_q    <= issued_q + 1'b1;
    end
  end

  a_r11_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid |=> !csr_valid);

  a_r3_incr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && seen_q && burst_incr && !cs_n_s) |-> csr_addr == ADDR_W'(prev_addr_q + 1'b1));

  a_r4_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && seen_q && !burst_incr && !cs_n_s) |-> csr_addr == prev_addr_q);

  a_r5_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && !cs_n_s) |-> issued_q < burst_words);

  a_r9_miso_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s)) |-> !spi_miso);

  a_r7_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid |-> !$past(cs_n_s));

endmodule

bind spi_csr_bridge bridge_checker #(
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .cs_n_s      (cs_n_s),
  .csr_valid   (csr_valid),
  .csr_addr    (csr_addr),
  .spi_miso    (spi_miso),
  .burst_incr  (burst_incr),
  .burst_words (burst_words)
);

// File: tb/tb_spi_csr_bridge.sv
module tb_spi_csr_bridge;

  localparam int HALF = 8;
  localparam logic [7:0] FIFO_A = 8'hA5;

  logic        clk;
  logic        rst_n;
  logic        spi_sclk;
  logic        spi_cs_n;
  logic        spi_mosi;
  logic        spi_miso;
  logic        csr_valid;
  logic        csr_we;
  logic [7:0]  csr_addr;
  logic [15:0] csr_wdata;
  logic [15:0] csr_rdata;
  logic        csr_rvalid;

  spi_csr_bridge dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .spi_mosi   (spi_mosi),
    .spi_miso   (spi_miso),
    .csr_valid  (csr_valid),
    .csr_we     (csr_we),
    .csr_addr   (csr_addr),
    .csr_wdata  (csr_wdata),
    .csr_rdata  (csr_rdata),
    .csr_rvalid (csr_rvalid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Register-port model: 256-word memory, FIFO-like port at FIFO_A.
  logic [15:0] mem [256];
  logic [7:0]  wlog_a [256];
  logic [15:0] wlog_d [256];
  int n_wr, n_rd, fifo_n, dbl;
  logic prev_v;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= {i[7:0], ~i[7:0]};
      n_wr <= 0; n_rd <= 0; fifo_n <= 0; dbl <= 0;
      prev_v <= 1'b0; csr_rvalid <= 1'b0; csr_rdata <= '0;
    end else begin
      prev_v     <= csr_valid;
      csr_rvalid <= 1'b0;
      if (csr_valid && prev_v) dbl <= dbl + 1;
      if (csr_valid) begin
        if (csr_we) begin
          mem[csr_addr]          <= csr_wdata;
          wlog_a[n_wr % 256]     <= csr_addr;
          wlog_d[n_wr % 256]     <= csr_wdata;
          n_wr <= n_wr + 1;
        end else begin
          csr_rvalid <= 1'b1;
          if (csr_addr == FIFO_A) begin
            csr_rdata <= 16'h5A00 + 16'(fifo_n);
            fifo_n    <= fifo_n + 1;
          end else begin
            csr_rdata <= mem[csr_addr];
          end
          n_rd <= n_rd + 1;
        end
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [15:0] txw [64];
  logic [15:0] rxw [64];
  int hdr_ones, miso_ones;

  task automatic spi_bit(input logic b, output logic m);
    spi_mosi = b;
    repeat (HALF) @(negedge clk);
    m = spi_miso;
    spi_sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sclk = 1'b0;
  endtask

  task automatic spi_txn(input logic wr, input logic incr, input logic [13:0] lm1,
                         input logic [7:0] a, input int nw, input int extra);
    logic [23:0] h;
    logic m;
    h = {wr, incr, lm1, a};
    hdr_ones = 0;
    miso_ones = 0;
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 23; i >= 0; i--) begin
      spi_bit(h[i], m);
      hdr_ones += int'(m);
    end
    for (int w = 0; w < nw; w++) begin
      for (int i = 15; i >= 0; i--) begin
        spi_bit(wr ? txw[w][i] : 1'b0, m);
        rxw[w][i] = m;
        miso_ones += int'(m);
      end
    end
    for (int i = 0; i < extra; i++) begin
      spi_bit(1'b1, m);
      miso_ones += int'(m);
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int wb, rb, fb;
    logic [15:0] exp_rd [64];
    logic [7:0]  ea;
    rst_n = 1'b0;
    spi_sclk = 1'b0;
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10: reset state
    chk(spi_miso == 1'b0, "R10 miso after reset", 32'(spi_miso), 0);
    chk(csr_valid == 1'b0, "R10 strobe after reset", 32'(csr_valid), 0);

    // Sweep: direction x addressing x length 1..5
    for (int wr = 0; wr < 2; wr++) begin
      for (int inc = 0; inc < 2; inc++) begin
        for (int n = 1; n <= 5; n++) begin
          logic [7:0] a;
          a = (inc == 1) ? 8'hFD : ((wr == 1) ? 8'h40 : FIFO_A);
          for (int k = 0; k < n; k++) begin
            txw[k] = 16'hC3A5 ^ 16'(k * 16'h0111) ^ 16'(n << 12) ^ 16'(inc << 8);
            ea = (inc == 1) ? 8'(a + k) : a;
            exp_rd[k] = (inc == 1) ? mem[ea] : 16'(16'h5A00 + 16'(fifo_n + k));
          end
          wb = n_wr; rb = n_rd;
          spi_txn(wr[0], inc[0], 14'(n - 1), a, n, 0);
          chk(hdr_ones == 0, "R9 miso zero in header", 32'(hdr_ones), 0);
          if (wr == 1) begin
            chk(n_wr - wb == n, "R5 write count", 32'(n_wr - wb), 32'(n));
            chk(n_rd == rb, "R2 no reads in write", 32'(n_rd - rb), 0);
            chk(miso_ones == 0, "R9 miso zero during write", 32'(miso_ones), 0);
            for (int k = 0; k < n; k++) begin
              ea = (inc == 1) ? 8'(a + k) : a;
              chk(wlog_a[(wb + k) % 256] == ea, (inc == 1) ? "R3 R1 incr write addr" : "R4 R1 fixed write addr",
                  32'(wlog_a[(wb + k) % 256]), 32'(ea));
              chk(wlog_d[(wb + k) % 256] == txw[k], "R2 write data", 32'(wlog_d[(wb + k) % 256]), 32'(txw[k]));
            end
          end else begin
            chk(n_rd - rb == n, "R5 read count", 32'(n_rd - rb), 32'(n));
            for (int k = 0; k < n; k++) begin
              chk(rxw[k] == exp_rd[k], (inc == 1) ? "R6 R3 incr read data" : "R6 R4 fixed read data",
                  32'(rxw[k]), 32'(exp_rd[k]));
            end
          end
        end
      end
    end

    // R7: abort mid-word on a write; partial word dropped
    txw[0] = 16'h1234; txw[1] = 16'hFFFF;
    wb = n_wr;
    spi_txn(1'b1, 1'b1, 14'd3, 8'h10, 1, 9);
    chk(n_wr - wb == 1, "R7 partial word dropped", 32'(n_wr - wb), 1);
    txw[0] = 16'hBEEF;
    wb = n_wr;
    spi_txn(1'b1, 1'b1, 14'd0, 8'h20, 1, 0);
    chk(n_wr - wb == 1, "R7 recovery count", 32'(n_wr - wb), 1);
    chk(wlog_a[wb % 256] == 8'h20, "R7 recovery addr", 32'(wlog_a[wb % 256]), 32'h20);
    chk(wlog_d[wb % 256] == 16'hBEEF, "R7 recovery data", 32'(wlog_d[wb % 256]), 32'hBEEF);

    // R6: abort in a read; prefetch stops at the word boundary
    rb = n_rd;
    spi_txn(1'b0, 1'b1, 14'd3, 8'h30, 1, 5);
    chk(n_rd - rb == 2, "R6 read prefetch after abort", 32'(n_rd - rb), 2);

    // R8: extra words after the counted ones
    txw[0] = 16'h0F0F; txw[1] = 16'hAAAA; txw[2] = 16'h5555;
    wb = n_wr;
    spi_txn(1'b1, 1'b0, 14'd0, 8'h50, 3, 0);
    chk(n_wr - wb == 1, "R8 extra write words ignored", 32'(n_wr - wb), 1);
    chk(mem[8'h50] == 16'h0F0F, "R8 target keeps first word", 32'(mem[8'h50]), 32'h0F0F);
    exp_rd[0] = mem[8'h60];
    rb = n_rd;
    spi_txn(1'b0, 1'b1, 14'd0, 8'h60, 3, 0);
    chk(n_rd - rb == 1, "R8 extra read words no access", 32'(n_rd - rb), 1);
    chk(rxw[0] == exp_rd[0], "R8 R6 counted read word", 32'(rxw[0]), 32'(exp_rd[0]));
    chk(rxw[1] == 16'h0 && rxw[2] == 16'h0, "R8 miso zero after count", 32'({rxw[1], rxw[2]}), 0);

    // R5: full-width count field does not end early
    txw[0] = 16'h7001; txw[1] = 16'h7002;
    wb = n_wr;
    spi_txn(1'b1, 1'b1, 14'h3FFF, 8'hFF, 2, 0);
    chk(n_wr - wb == 2, "R5 max count field", 32'(n_wr - wb), 2);
    chk(wlog_a[(wb + 1) % 256] == 8'h00, "R3 wrap at max count", 32'(wlog_a[(wb + 1) % 256]), 0);

    chk(dbl == 0, "R11 strobe single cycle", 32'(dbl), 0);
    chk(spi_miso == 1'b0, "R9 miso idle at end", 32'(spi_miso), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule